// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is a single pulse-width-modulation timer channel. A 24-bit up-counter advances on a counter clock after a programmable prescaler that divides by 1, 16, 256 or 2048. The counter runs from zero up to a programmed cycle value and then clears. The output sits in its first phase while the count is below a programmed compare value and in its second phase for the rest of the period. Without inversion the first phase is low and the second phase is high. A polarity bit swaps the two levels. If the compare value is zero, the output stays in its second phase for the whole period. If the compare value exceeds the cycle value, the output stays in its first phase for the whole period. For that reason software keeps the cycle value below the counter's all-ones value.

Software programs the channel through a small register port on a bus clock. The bus clock has no fixed relation to the counter clock, and either one may be the faster. Configuration crosses to the counter side as a single coherent word through a toggle handshake. A busy bit stays set until the last written value has arrived. Three events come back from the counter side: a rising edge of the output, a falling edge of the output, and the counter clear at the end of each period. These events set sticky flags on the bus side. Each flag has its own enable mask bit, and the masked flags are ORed into one registered interrupt line. Software changes period and polarity only while the channel is stopped.

Top module: `pwmt_channel`

## Requirements
- R1: After reset, every register reads 0, `pwm_out` is 0 and `irq` is 0. The register addresses are 0 control, 1 cycle, 2 compare, 3 flags, 4 mask.
- R2: While enabled, the output repeats with a period of (cycle+1) × ratio counter-clock cycles.
- R3: Control bits [3:2] select the prescale ratio: 0 selects 1, 1 selects 16, 2 selects 256 and 3 selects 2048.
- R4: With control bit 1 (invert) at 0, each period is low for min(compare, cycle+1) × ratio counter clocks and high for the rest. If both parts are non-zero, there is exactly one rising edge per period; otherwise the output is constant.
- R5: With invert at 1, the levels are swapped, so the output is high for min(compare, cycle+1) × ratio counter clocks of each period.
- R6: With control bit 0 (enable) at 0, the counter stays at zero, the output holds the invert bit's value, and no new flag is set.
- R7: Flags register bit 0 records a rising edge, bit 1 a falling edge and bit 2 a counter clear. Each bit stays set until software writes 1 to it. Writing 0 to a bit leaves it unchanged.
- R8: `irq` equals the OR of the flags ANDed with mask register bits [2:0].
- R9: Flags register bit 8 reads 1 from a write to the control, cycle or compare register until the value is in force. Writes made while this bit is set are not lost, and the last value written is the one applied.
- R10: While enabled, the clear flag is set once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus side |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data, registered, one cycle after the address |
| irq | output | 1 | Masked OR of the sticky flags |
| cnt_clk | input | 1 | Counter clock |
| cnt_rst | input | 1 | Synchronous active-high reset, counter side |
| pwm_out | output | 1 | PWM output, registered on the counter clock |

## Verification
The hardest state to reach from the ports is a configuration word that changes while an earlier transfer is still crossing between the clocks. The stimulus always writes a throw-away compare value immediately followed by the real one. This lands the second write inside the handshake window, and the measured duty and period then show whether the last value won. The slow prescale settings produce periods of thousands of counter clocks, so only a few directed cases use them. Short random cycle and compare values cover the boundaries: compare zero, compare equal to cycle+1 and compare above it. Output levels are counted over windows of whole periods, which makes each check independent of the phase at which the window starts.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int CNT_W = 24;
  localparam int PRE_W = 11;
  localparam int DW    = CNT_W;
  localparam int AW    = 3;
  localparam int NEVT  = 3;
  localparam int BUSY_BIT = 8;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_CYC  = 3'd1;
  localparam logic [AW-1:0] A_CMP  = 3'd2;
  localparam logic [AW-1:0] A_FLAG = 3'd3;
  localparam logic [AW-1:0] A_MASK = 3'd4;

  localparam int EV_RISE = 0;
  localparam int EV_FALL = 1;
  localparam int EV_CLR  = 2;

  typedef struct packed {
    logic             en;
    logic             inv;
    logic [1:0]       psel;
    logic [CNT_W-1:0] cyc;
    logic [CNT_W-1:0] cmp;
  } cfg_t;

  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return '0;
      2'd1:    return PRE_W'(15);
      2'd2:    return PRE_W'(255);
      default: return PRE_W'(2047);
    endcase
  endfunction
endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NEVT-1:0] evt_pulse,
  input  logic            busy,
  output cfg_t            cfg_o,
  output logic            cfg_wr,
  output logic            irq_o
);
  cfg_t            cfg_q;
  logic [NEVT-1:0] flags_q, mask_q, flags_n, mask_n;
  logic [DW-1:0]   rd_n;
  logic            wr_ctrl, wr_cyc, wr_cmp, wr_flag, wr_mask;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cyc  = wr_en && (addr == A_CYC);
  assign wr_cmp  = wr_en && (addr == A_CMP);
  assign wr_flag = wr_en && (addr == A_FLAG);
  assign wr_mask = wr_en && (addr == A_MASK);

  always_comb begin
    flags_n = (flags_q & ~(wr_flag ? wdata[NEVT-1:0] : '0)) | evt_pulse;
    mask_n  = wr_mask ? wdata[NEVT-1:0] : mask_q;
  end

  always_comb begin
    rd_n = '0;
    case (addr)
      A_CTRL: rd_n[3:0] = {cfg_q.psel, cfg_q.inv, cfg_q.en};
      A_CYC:  rd_n = cfg_q.cyc;
      A_CMP:  rd_n = cfg_q.cmp;
      A_FLAG: begin
        rd_n[NEVT-1:0] = flags_q;
        rd_n[BUSY_BIT] = busy;
      end
      A_MASK: rd_n[NEVT-1:0] = mask_q;
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      flags_q <= '0;
      mask_q  <= '0;
      cfg_wr  <= 1'b0;
      irq_o   <= 1'b0;
      rdata   <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg_q.en   <= wdata[0];
        cfg_q.inv  <= wdata[1];
        cfg_q.psel <= wdata[3:2];
      end
      if (wr_cyc) cfg_q.cyc <= wdata;
      if (wr_cmp) cfg_q.cmp <= wdata;
      cfg_wr  <= wr_ctrl | wr_cyc | wr_cmp;
      flags_q <= flags_n;
      mask_q  <= mask_n;
      irq_o   <= |(flags_n & mask_n);
      rdata   <= rd_n;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pwmt_cfg_cdc.sv
module pwmt_cfg_cdc
  import pwmt_pkg::*;
(
  input  logic b_clk,
  input  logic b_rst,
  input  cfg_t cfg_in,
  input  logic cfg_wr,
  output logic busy_o,
  input  logic c_clk,
  input  logic c_rst,
  output cfg_t cfg_out
);
  cfg_t xfer_q, cfg_q;
  logic pend_q, req_q, ack_s1, ack_s2, idle;
  logic req_s1, req_s2, ack_q;

  assign idle   = (ack_s2 == req_q);
  assign busy_o = pend_q | ~idle;

  always_ff @(posedge b_clk) begin
    if (b_rst) begin
      xfer_q <= '0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_q;
      ack_s2 <= ack_s1;
      if (pend_q && idle) begin
        xfer_q <= cfg_in;
        req_q  <= ~req_q;
        pend_q <= 1'b0;
      end
      if (cfg_wr) pend_q <= 1'b1;
    end
  end

  always_ff @(posedge c_clk) begin
    if (c_rst) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      ack_q  <= 1'b0;
      cfg_q  <= '0;
    end else begin
      req_s1 <= req_q;
      req_s2 <= req_s1;
      if (req_s2 != ack_q) begin
        cfg_q <= xfer_q;
        ack_q <= req_s2;
      end
    end
  end

  assign cfg_out = cfg_q;
endmodule

// File: rtl/pwmt_evt_cdc.sv
module pwmt_evt_cdc
  import pwmt_pkg::*;
(
  input  logic            c_clk,
  input  logic            c_rst,
  input  logic [NEVT-1:0] evt_in,
  input  logic            b_clk,
  input  logic            b_rst,
  output logic [NEVT-1:0] pulse_out
);
  logic [NEVT-1:0] tgl_q, s1, s2, s3;

  always_ff @(posedge c_clk) begin
    if (c_rst) tgl_q <= '0;
    else       tgl_q <= tgl_q ^ evt_in;
  end

  always_ff @(posedge b_clk) begin
    if (b_rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= tgl_q;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign pulse_out = s2 ^ s3;
endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
  import pwmt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  cfg_t            cfg,
  output logic            pwm_o,
  output logic [NEVT-1:0] evt_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pwm_q, clr_q, rise_q, fall_q;
  logic             tick, nxt;

  assign tick = (pre_q >= pre_limit(cfg.psel));
  assign nxt  = cfg.en ? ((cnt_q < cfg.cmp) ? cfg.inv : ~cfg.inv) : cfg.inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      clr_q  <= 1'b0;
      pwm_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (!cfg.en) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        pre_q <= '0;
        if (cnt_q >= cfg.cyc) begin
          cnt_q <= '0;
          clr_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
      pwm_q  <= nxt;
      rise_q <= nxt & ~pwm_q;
      fall_q <= ~nxt & pwm_q;
    end
  end

  assign pwm_o = pwm_q;
  always_comb begin
    evt_o          = '0;
    evt_o[EV_RISE] = rise_q;
    evt_o[EV_FALL] = fall_q;
    evt_o[EV_CLR]  = clr_q;
  end
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
(
  input  logic          bus_clk,
  input  logic          bus_rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic          cnt_clk,
  input  logic          cnt_rst,
  output logic          pwm_out
);
  cfg_t            b_cfg, c_cfg;
  logic            cfg_wr, busy;
  logic [NEVT-1:0] c_evt, b_pulse;

  pwmt_regs u_regs (
    .clk(bus_clk), .rst(bus_rst), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .evt_pulse(b_pulse),
    .busy(busy), .cfg_o(b_cfg), .cfg_wr(cfg_wr), .irq_o(irq)
  );

  pwmt_cfg_cdc u_cfg_cdc (
    .b_clk(bus_clk), .b_rst(bus_rst), .cfg_in(b_cfg), .cfg_wr(cfg_wr),
    .busy_o(busy), .c_clk(cnt_clk), .c_rst(cnt_rst), .cfg_out(c_cfg)
  );

  pwmt_core u_core (
    .clk(cnt_clk), .rst(cnt_rst), .cfg(c_cfg), .pwm_o(pwm_out), .evt_o(c_evt)
  );

  pwmt_evt_cdc u_evt_cdc (
    .c_clk(cnt_clk), .c_rst(cnt_rst), .evt_in(c_evt),
    .b_clk(bus_clk), .b_rst(bus_rst), .pulse_out(b_pulse)
  );
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_core_chk
  import pwmt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             inv,
  input logic [CNT_W-1:0] cyc,
  input logic [PRE_W-1:0] pre_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             pwm_q,
  input logic             clr_q,
  input logic [1:0]       edge_evt
);
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en) && $stable(inv)) |-> (cnt_q == '0 && pre_q == '0 && pwm_q == inv));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && $stable(cyc) && $past(cnt_q <= cyc)) |-> (cnt_q <= cyc));

  assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (rst)
    clr_q |-> (cnt_q == '0));

  assert_edge_excl_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(edge_evt));
endmodule

module pwmt_regs_chk
  import pwmt_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [NEVT-1:0] w1c_data,
  input logic [NEVT-1:0] evt_pulse,
  input logic [NEVT-1:0] flags_q,
  input logic [NEVT-1:0] mask_q,
  input logic            irq_o
);
  logic [NEVT-1:0] prev_f, w1c_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_f <= '0;
      w1c_q  <= '0;
    end else begin
      prev_f <= flags_q;
      w1c_q  <= (wr_en && addr == A_FLAG) ? w1c_data : '0;
    end
  end

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    &(~(prev_f & ~w1c_q) | flags_q));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
    (|evt_pulse) |=> ((flags_q & $past(evt_pulse)) == $past(evt_pulse)));

  assert_irq_or_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(flags_q & mask_q));
endmodule

bind pwmt_core pwmt_core_chk u_core_chk (
  .clk(clk), .rst(rst), .en(cfg.en), .inv(cfg.inv), .cyc(cfg.cyc),
  .pre_q(pre_q), .cnt_q(cnt_q), .pwm_q(pwm_q), .clr_q(clr_q),
  .edge_evt(evt_o[1:0])
);

bind pwmt_regs pwmt_regs_chk u_regs_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .w1c_data(wdata[2:0]), .evt_pulse(evt_pulse), .flags_q(flags_q),
  .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/pwmt_channel_tb.sv
`timescale 1ns/100ps
module pwmt_channel_tb;
  logic        bclk = 1'b0, cclk = 1'b0;
  logic        brst = 1'b1, crst = 1'b1;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic        irq, pwm;
  int          checks = 0, errors = 0;
  int          seed_v;

  always #2.0 bclk = ~bclk;
  always #3.3 cclk = ~cclk;

  pwmt_channel u_dut (
    .bus_clk(bclk), .bus_rst(brst), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq),
    .cnt_clk(cclk), .cnt_rst(crst), .pwm_out(pwm)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int sel);
    return (sel == 3) ? 2048 : (1 << (4 * sel));
  endfunction

  task automatic wr_reg(input int a, input int d);
    @(negedge bclk);
    wr = 1'b1; addr = 3'(a); wdata = 24'(d);
    @(negedge bclk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [23:0] v);
    @(negedge bclk);
    addr = 3'(a);
    @(negedge bclk);
    v = rdata;
  endtask

  task automatic wait_idle();
    logic [23:0] v;
    v = '1;
    for (int i = 0; i < 200; i++) begin
      rd_reg(3, v);
      if (!v[8]) break;
    end
    chk(!v[8], "R9 busy clears", v[8], 0);
  endtask

  task automatic measure(input int n, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0;
    @(negedge cclk);
    prev = pwm;
    for (int i = 0; i < n; i++) begin
      @(negedge cclk);
      if (pwm) hi++;
      if (pwm && !prev) rises++;
      prev = pwm;
    end
  endtask

  task automatic run_case(input int cyc, input int cmp, input int psel, input int inv, input int mask);
    int r, per, lo, hi_len, hi, rises, n;
    bit edges, found;
    logic prev;
    logic [23:0] v;
    logic [2:0] fexp;
    r = ratio(psel);
    per = (cyc + 1) * r;
    lo = ((cmp < cyc + 1) ? cmp : cyc + 1) * r;
    hi_len = per - lo;
    edges = (lo > 0) && (hi_len > 0);
    wr_reg(0, (psel << 2) | (inv << 1));
    wait_idle();
    wr_reg(1, cyc);
    wr_reg(2, cmp ^ 5);
    wr_reg(2, cmp);
    rd_reg(3, v);
    chk(v[8] == 1'b1, "R9 busy set after write", v[8], 1);
    wait_idle();
    wr_reg(4, mask);
    wr_reg(0, (psel << 2) | (inv << 1) | 1);
    wait_idle();
    repeat (per + 40) @(negedge cclk);
    wr_reg(3, 7);
    if (edges) begin
      found = 0;
      @(negedge cclk);
      prev = pwm;
      for (int i = 0; i < 2 * per + 4 && !found; i++) begin
        @(negedge cclk);
        if (pwm && !prev) found = 1;
        prev = pwm;
      end
      n = 0; found = 0;
      for (int i = 0; i < 2 * per + 4 && !found; i++) begin
        @(negedge cclk);
        n++;
        if (pwm && !prev) found = 1;
        prev = pwm;
      end
      chk(found && n == per, "R2 R3 period", n, per);
    end
    measure(2 * per, hi, rises);
    chk(hi == 2 * (inv ? lo : hi_len), inv ? "R5 high time inverted" : "R4 high time", hi,
        2 * (inv ? lo : hi_len));
    chk(rises == (edges ? 2 : 0), "R4 rising edges per window", rises, edges ? 2 : 0);
    rd_reg(3, v);
    fexp = {1'b1, edges, edges};
    chk(v[2:0] == fexp, "R7 R10 flags after run", v[2:0], fexp);
    chk(irq == |(fexp & 3'(mask)), "R8 irq", irq, |(fexp & 3'(mask)));
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] v;
    int hi, rises;
    seed_v = $urandom(32'h5eed);
    fork
      begin repeat (10) @(negedge bclk); brst = 1'b0; end
      begin repeat (10) @(negedge cclk); crst = 1'b0; end
    join
    repeat (5) @(negedge bclk);

    for (int a = 0; a < 5; a++) begin
      rd_reg(a, v);
      chk(v == 0, "R1 register reset value", v, 0);
    end
    chk(pwm == 1'b0, "R1 pwm_out reset", pwm, 0);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);

    run_case(3, 0, 0, 0, 1);
    run_case(3, 4, 0, 1, 2);
    run_case(3, 9, 0, 0, 7);
    run_case(3, 1, 1, 0, 7);
    run_case(2, 1, 2, 0, 3);
    run_case(1, 1, 3, 1, 5);

    for (int k = 0; k < 10; k++) begin
      int c, m;
      c = 1 + int'($urandom % 15);
      m = int'($urandom % (c + 3));
      run_case(c, m, int'($urandom % 2), int'($urandom % 2), int'($urandom % 8));
    end

    run_case(3, 2, 0, 0, 7);
    wr_reg(0, 0);
    wait_idle();
    repeat (50) @(negedge cclk);
    rd_reg(3, v);
    chk(v[2:0] == 3'b111, "R7 flags held after stop", v[2:0], 7);
    wr_reg(3, 0);
    rd_reg(3, v);
    chk(v[2:0] == 3'b111, "R7 write 0 ignored", v[2:0], 7);
    wr_reg(3, 1);
    rd_reg(3, v);
    chk(v[2:0] == 3'b110, "R7 write 1 clears bit", v[2:0], 6);
    chk(irq == 1'b1, "R8 irq with remaining flags", irq, 1);
    wr_reg(3, 6);
    rd_reg(3, v);
    chk(v[2:0] == 3'b000, "R7 all cleared", v[2:0], 0);
    chk(irq == 1'b0, "R8 irq low", irq, 0);

    wr_reg(0, 2);
    wait_idle();
    repeat (40) @(negedge cclk);
    wr_reg(3, 7);
    measure(300, hi, rises);
    chk(hi == 300, "R6 idle level follows invert", hi, 300);
    chk(rises == 0, "R6 no edges while stopped", rises, 0);
    rd_reg(3, v);
    chk(v[2:0] == 3'b000, "R6 no flags while stopped", v[2:0], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule